// File: doc/BRIEF.md
# Quadratic Permutation Address Generator

This block walks through the interleaved positions of one code block. Each position is given by the quadratic polynomial (f1·i + f2·i²) mod K. After a start strobe it samples the block length K and the two coefficients. It then puts out one address per clock for i = 0, 1, …, K−1, with a valid flag and a flag that marks the final address. A memory controller or a set of parallel soft-decision decoders uses the addresses to read or write their buffers in interleaved order. A well-chosen coefficient pair gives a contention-free pattern, so banked memories see no access conflicts.

The addresses come from a running-sum recursion in modular arithmetic. The current address grows by an increment, and the increment grows by 2·f2. Every operand stays below K, so each step is one addition followed by at most one subtraction of K. The block has no multiplier and holds no permutation table. A new block may start in the same cycle that the previous block issues its last address, so blocks can follow each other with no idle cycle.

Top module: `qpp_addr_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `valid_o` and `last_o` are low.
- R2: A `start_i` pulse sampled while idle makes `valid_o` high on the next cycle, with `addr_o` = 0 for index 0.
- R3: While the block runs, `addr_o` in its n-th valid cycle (n counted from 0) equals (f1·n + f2·n²) mod K, one address per consecutive cycle, where K, f1 and f2 are the values sampled at the start.
- R4: A block produces exactly K consecutive valid cycles. `last_o` is high only in the cycle of index K−1, and always together with `valid_o`.
- R5: For a coefficient pair that forms a valid permutation, the K addresses of a block are all distinct and cover 0..K−1.
- R6: After the last address, if `start_i` is low in that cycle, `valid_o` is low on the next cycle.
- R7: If `start_i` is high in the cycle where `last_o` is high, the new block's index 0 (address 0) appears on the next cycle with no gap.
- R8: `start_i`, `len_i`, `coef1_i` and `coef2_i` are ignored while a block runs and its last address has not yet been issued. The running sequence and its length do not change.
- R9: Every valid address is below the sampled K.
- R10: The block handles K from 40 to 6144 inclusive, given f1 < K and f2 < K, including both end values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a block; samples len_i, coef1_i, coef2_i |
| len_i | input | AW (13) | Block length K |
| coef1_i | input | AW (13) | Linear coefficient f1, below K |
| coef2_i | input | AW (13) | Quadratic coefficient f2, below K |
| valid_o | output | 1 | addr_o holds an address |
| last_o | output | 1 | Current address is index K−1 |
| addr_o | output | AW (13) | Interleaved address |

## Verification
Two events can fall in the same cycle. One is the issue of a block's final address. The other is the acceptance of the next block's start. The bench provokes this by raising `start_i` exactly in the cycle where it sees `last_o`, with a different length and different coefficients. It then checks that index 0 of the new block follows the old last address directly, and that both blocks keep their full lengths and their permutation property. The mirror case is also driven: start pulses and changed parameters inside a running block, which must neither restart it nor cut it short.

// File: rtl/qpp_pkg.sv
package qpp_pkg;
    localparam int QPP_AW = 13;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } qpp_phase_e;
endpackage

// File: rtl/qpp_mod_add.sv
// (a + b) mod m for operands already below m: one add, one conditional subtract.
module qpp_mod_add #(
    parameter int AW = qpp_pkg::QPP_AW
) (
    input  logic [AW-1:0] a,
    input  logic [AW-1:0] b,
    input  logic [AW-1:0] m,
    output logic [AW-1:0] r
);
    logic [AW:0] sum_w;
    logic        wrap_w;

    always_comb begin
        sum_w  = {1'b0, a} + {1'b0, b};
        wrap_w = (sum_w >= {1'b0, m});
        // truncated arithmetic is exact because the true result is below m
        r      = wrap_w ? (a + b - m) : (a + b);
    end
endmodule

// File: rtl/qpp_end_det.sv
// Flags the final index of a block.
module qpp_end_det #(
    parameter int AW = qpp_pkg::QPP_AW
) (
    input  logic          run,
    input  logic [AW-1:0] idx,
    input  logic [AW-1:0] len,
    output logic          at_end
);
    always_comb begin
        at_end = run && (idx == (len - 1'b1));
    end
endmodule

// File: rtl/qpp_addr_gen.sv
module qpp_addr_gen #(
    parameter int AW = qpp_pkg::QPP_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] len_i,
    input  logic [AW-1:0] coef1_i,
    input  logic [AW-1:0] coef2_i,
    output logic          valid_o,
    output logic          last_o,
    output logic [AW-1:0] addr_o
);
    import qpp_pkg::*;

    localparam logic [AW-1:0] ZERO = '0;
    localparam logic [AW-1:0] ONE  = AW'(1);

    typedef struct packed {
        qpp_phase_e    ph;
        logic [AW-1:0] idx;   // current index i
        logic [AW-1:0] pi;    // address for index i
        logic [AW-1:0] g;     // increment from i to i+1
        logic [AW-1:0] step;  // 2*f2 mod K
        logic [AW-1:0] k;     // sampled block length
    } gen_state_t;

    gen_state_t st_d, st_q;

    logic          at_end_w;
    logic          accept_w;
    logic [AW-1:0] g0_w, step0_w, pi_nx_w, g_nx_w;

    // seeds from the sampled inputs
    qpp_mod_add #(.AW(AW)) u_seed_g (
        .a(coef1_i), .b(coef2_i), .m(len_i), .r(g0_w)
    );
    qpp_mod_add #(.AW(AW)) u_seed_step (
        .a(coef2_i), .b(coef2_i), .m(len_i), .r(step0_w)
    );

    // running recursion
    qpp_mod_add #(.AW(AW)) u_next_pi (
        .a(st_q.pi), .b(st_q.g), .m(st_q.k), .r(pi_nx_w)
    );
    qpp_mod_add #(.AW(AW)) u_next_g (
        .a(st_q.g), .b(st_q.step), .m(st_q.k), .r(g_nx_w)
    );

    qpp_end_det #(.AW(AW)) u_end (
        .run   (st_q.ph == PH_RUN),
        .idx   (st_q.idx),
        .len   (st_q.k),
        .at_end(at_end_w)
    );

    always_comb begin
        st_d     = st_q;
        accept_w = start_i && ((st_q.ph == PH_IDLE) || at_end_w);
        if (accept_w) begin
            st_d.ph   = PH_RUN;
            st_d.idx  = ZERO;
            st_d.pi   = ZERO;
            st_d.g    = g0_w;
            st_d.step = step0_w;
            st_d.k    = len_i;
        end else if (st_q.ph == PH_RUN) begin
            if (at_end_w) begin
                st_d.ph = PH_IDLE;
            end else begin
                st_d.idx = st_q.idx + ONE;
                st_d.pi  = pi_nx_w;
                st_d.g   = g_nx_w;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, idx: ZERO, pi: ZERO, g: ZERO, step: ZERO, k: ZERO};
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = (st_q.ph == PH_RUN);
    assign last_o  = at_end_w;
    assign addr_o  = st_q.pi;
endmodule

// File: rtl/qpp_addr_gen_chk.sv
module qpp_addr_gen_chk #(
    parameter int AW = qpp_pkg::QPP_AW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          valid_o,
    input logic          last_o,
    input logic [AW-1:0] addr_o,
    input logic [AW-1:0] k_q
);
    // R2
    first_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> (addr_o == '0));

    // R4
    last_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    // R6
    idle_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !valid_o);

    // R7
    chained_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && start_i) |=> (valid_o && addr_o == '0));

    // R8
    busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> (valid_o && $stable(k_q)));

    // R9
    addr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (addr_o < k_q));
endmodule

bind qpp_addr_gen qpp_addr_gen_chk #(.AW(AW)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .valid_o(valid_o),
    .last_o (last_o),
    .addr_o (addr_o),
    .k_q    (st_q.k)
);

// File: tb/qpp_addr_gen_tb.sv
module qpp_addr_gen_tb_top;
    localparam int AW = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] len_i = '0;
    logic [AW-1:0] coef1_i = '0;
    logic [AW-1:0] coef2_i = '0;
    logic          valid_o, last_o;
    logic [AW-1:0] addr_o;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    qpp_addr_gen #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
        .coef1_i(coef1_i), .coef2_i(coef2_i),
        .valid_o(valid_o), .last_o(last_o), .addr_o(addr_o)
    );

    // behavioural reference
    bit m_busy = 1'b0;
    int m_i = 0, m_k = 1, m_f1 = 0, m_f2 = 0;
    bit seen [0:8191];
    int distinct = 0;
    int blk_len = 0;      // valid cycles counted in the current block
    int done_len = 0;     // length of the most recently finished block
    int done_distinct = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0;
        end else begin
            if (start_i && (!m_busy || m_i == m_k - 1)) begin
                m_busy = 1'b1; m_i = 0; m_k = int'(len_i);
                m_f1 = int'(coef1_i); m_f2 = int'(coef2_i);
            end else if (m_busy) begin
                if (m_i == m_k - 1) m_busy = 1'b0;
                else m_i++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(valid_o == m_busy, m_busy ? "R2" : "R6", valid_o, m_busy);
            if (m_busy && valid_o) begin
                longint e;
                e = (longint'(m_f1) * m_i + longint'(m_f2) * m_i * m_i) % m_k;
                if (m_i == 0) begin
                    for (int j = 0; j < 8192; j++) seen[j] = 1'b0;
                    distinct = 0;
                    blk_len = 0;
                end
                check(longint'(addr_o) == e, (m_i == 0) ? "R2" : "R3", addr_o, e);
                check(int'(addr_o) < m_k, "R9", addr_o, m_k);
                check(last_o == (m_i == m_k - 1), "R4", last_o, (m_i == m_k - 1));
                if (!seen[addr_o]) begin
                    seen[addr_o] = 1'b1;
                    distinct++;
                end
                blk_len++;
                if (m_i == m_k - 1) begin
                    done_len = blk_len;
                    done_distinct = distinct;
                end
            end else begin
                check(last_o == 1'b0, "R4", last_o, 0);
            end
        end
    end

    task automatic drive_start(input int k, input int f1, input int f2);
        start_i = 1'b1;
        len_i = AW'(k); coef1_i = AW'(f1); coef2_i = AW'(f2);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_last();
        while (!last_o) @(negedge clk);
    endtask

    task automatic check_block(input int k, input string req);
        check(done_len == k, req, done_len, k);
        check(done_distinct == k, "R5", done_distinct, k);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(valid_o == 1'b0 && last_o == 1'b0, "R1", {valid_o, last_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(valid_o == 1'b0 && last_o == 1'b0, "R1", {valid_o, last_o}, 0);

        // smallest length, then idle (R10, R6)
        drive_start(40, 3, 10);
        wait_last();
        @(negedge clk);
        check(valid_o == 1'b0, "R6", valid_o, 0);
        check_block(40, "R10");

        // disturbances inside a running block (R8)
        @(negedge clk);
        drive_start(48, 7, 12);
        repeat (5) @(negedge clk);
        start_i = 1'b1; len_i = 13'd100; coef1_i = 13'd9; coef2_i = 13'd20;
        @(negedge clk);
        start_i = 1'b0;
        repeat (10) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; len_i = 13'd44;
        wait_last();
        @(negedge clk);
        check_block(48, "R8");
        check(valid_o == 1'b0, "R8", valid_o, 0);

        // back-to-back blocks (R7)
        @(negedge clk);
        drive_start(104, 7, 26);
        wait_last();
        drive_start(512, 31, 64);
        check(valid_o == 1'b1 && addr_o == '0, "R7", addr_o, 0);
        check_block(104, "R4");
        wait_last();
        drive_start(1024, 31, 64);
        check(valid_o == 1'b1 && addr_o == '0, "R7", addr_o, 0);
        check_block(512, "R7");
        wait_last();
        @(negedge clk);
        check_block(1024, "R4");

        // largest length (R10)
        drive_start(6144, 263, 480);
        wait_last();
        @(negedge clk);
        check_block(6144, "R10");
        check(valid_o == 1'b0, "R6", valid_o, 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule